// File: doc/BRIEF.md
# Condition Code Branch Evaluator

This block sits beside the instruction decoder of a 16-bit processor. It takes the current instruction word, the program counter (which already points at the word after the instruction), the four condition flags and one general register value. In the same cycle it says whether the word belongs to one of the three instruction groups it handles, whether control moves, and where it moves to. The three groups are the conditional branches, the decrement-and-loop instruction and the flag set/clear operations.

The branch group uses an 8-bit opcode byte and an 8-bit signed word offset. The loop instruction decrements the supplied register. While the result is nonzero, it jumps backwards by a 6-bit unsigned word count. The flag operations set or clear any subset of the flags, chosen by a 4-bit mask. All decode and target arithmetic is combinational. The updated flag nibble is also held in a register, which loads only when a flag operation is presented while `en` is high.

Flags are ordered N, Z, V, C from bit 3 down to bit 0 in every nibble: `flags_in`, `flags_next`, `flags_q` and the mask field.

Top module: `ccb_eval`

## Requirements
- R1: For a branch word (high byte 0x01..0x07 or 0x80..0x87) whose condition holds, `taken`=1 and `target_pc` = `pc_in` + 2 × (low byte read as a signed 8-bit value), taken modulo 2^16.
- R2: The high bytes 0x01..0x07 test, in order: always; Z=0; Z=1; N=V; N≠V; Z=0 and N=V; Z=1 or N≠V.
- R3: The high bytes 0x80..0x87 test, in order: N=0; N=1; C=0 and Z=0; C=1 or Z=1; V=0; V=1; C=0; C=1.
- R4: When `taken`=0, `target_pc` equals `pc_in` with bit 0 cleared.
- R5: The words 0x00A0..0x00AF give `flags_next` = `flags_in` AND NOT mask, where the mask is bits 3:0 of the word. They also give `recognised`=1 and `taken`=0.
- R6: The words 0x00B0..0x00BF give `flags_next` = `flags_in` OR mask, with `recognised`=1 and `taken`=0. A zero mask leaves the flags as they are.
- R7: The loop word (bits 15:9 = 0111111, count in bits 5:0) gives `loop_dec` = `loop_reg` − 1 modulo 2^16. `taken` is 1 exactly when `loop_dec` is nonzero, and the taken target is `pc_in` − 2 × count modulo 2^16.
- R8: Any other word gives `recognised`=0 and `taken`=0, with `flags_next` = `flags_in`. For every word that is not a loop word, `loop_dec` = `loop_reg`.
- R9: `flags_q` resets to 0 and loads `flags_next` on a clock edge only when `en`=1 and the word is a flag operation; otherwise it holds.
- R10: Bit 0 of `target_pc` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Allows the flag register to load |
| instr | input | 16 | Instruction word |
| pc_in | input | 16 | Program counter, already past the instruction word |
| flags_in | input | 4 | Current flags {N,Z,V,C} |
| loop_reg | input | 16 | Register value used by the loop instruction |
| recognised | output | 1 | Word belongs to one of the three handled groups |
| taken | output | 1 | Control moves to `target_pc` |
| target_pc | output | 16 | Next program counter |
| loop_dec | output | 16 | Register value after the loop instruction |
| flags_next | output | 4 | Updated flag nibble (combinational) |
| flags_q | output | 4 | Registered flag nibble |

## Verification
Every value of the high byte is swept against all sixteen flag combinations. This shows that each of the fifteen branch conditions separates the flag patterns exactly as its rule says, and that opcode bytes next to the branch ranges are not decoded as branches. Low bytes 0x00, 0x7F, 0x80 and 0xFF separate the two offset extremes and the sign extension. PC values near 0 and 0xFFFE, plus one odd PC, show wraparound and the cleared bit 0. Loop register values 1, 0 and others tell the fall-through case apart from the jump and from the wrap of the decrement. A clocked sequence shows that the flag register loads only on a flag operation with `en` high.

// File: rtl/ccb_pkg.sv
// Package for the condition code branch evaluator.
// Holds the word-class encoding and the flag nibble layout shared by all modules.
package ccb_pkg;

    // Class of the incoming instruction word
    typedef enum logic [1:0] {
        K_NONE   = 2'd0,
        K_BRANCH = 2'd1,
        K_LOOP   = 2'd2,
        K_FLAGOP = 2'd3
    } word_kind_t;

    // Positions of the flags inside every 4-bit nibble
    localparam int FLAG_N = 3;
    localparam int FLAG_Z = 2;
    localparam int FLAG_V = 1;
    localparam int FLAG_C = 0;

endpackage

// File: rtl/ccb_decode.sv
// Instruction word classifier.
// Splits a word into its class and fields. It assumes the fixed encoding:
// branch byte in bits 15:8, loop prefix in bits 15:9, flag operations 0x00A0..0x00BF.
module ccb_decode
    import ccb_pkg::*;
#(
    parameter int W     = 16,
    parameter int OFF_W = 8,
    parameter int CNT_W = 6,
    parameter int FLG_W = 4
) (
    input  logic [W-1:0]     instr,
    output word_kind_t       kind,
    output logic [3:0]       cond_sel,
    output logic [OFF_W-1:0] offset,
    output logic [CNT_W-1:0] count,
    output logic [FLG_W-1:0] mask,
    output logic             set_op
);
    localparam int HI_LSB = W - 8;

    logic [7:0] hi_byte;
    logic       is_branch;
    logic       is_loop;
    logic       is_flagop;

    assign hi_byte = instr[W-1:HI_LSB];

    // Recognise each of the three word groups
    always_comb begin
        is_branch = (hi_byte[6:3] == 4'd0) && (hi_byte[7] || (hi_byte[2:0] != 3'd0));
        is_loop   = (instr[W-1:W-7] == 7'b0111111);
        is_flagop = (instr[W-1:5] == {{(W-8){1'b0}}, 3'b101});
    end

    // Priority-free class select (the groups are disjoint)
    always_comb begin
        if (is_branch)      kind = K_BRANCH;
        else if (is_loop)   kind = K_LOOP;
        else if (is_flagop) kind = K_FLAGOP;
        else                kind = K_NONE;
    end

    // Field extraction
    assign cond_sel = {hi_byte[7], hi_byte[2:0]};
    assign offset   = instr[OFF_W-1:0];
    assign count    = instr[CNT_W-1:0];
    assign mask     = instr[FLG_W-1:0];
    assign set_op   = instr[4];

endmodule

// File: rtl/ccb_cond_eval.sv
// Branch condition evaluator.
// Maps the 4-bit condition select {signed/unsigned group, low 3 bits of the opcode byte}
// onto a test of the flags. Select 0_000 is not a branch and yields 0.
module ccb_cond_eval
    import ccb_pkg::*;
#(
    parameter int FLG_W = 4
) (
    input  logic [3:0]       cond_sel,
    input  logic [FLG_W-1:0] flags,
    output logic             cond_true
);
    logic n, z, v, c;

    assign n = flags[FLAG_N];
    assign z = flags[FLAG_Z];
    assign v = flags[FLAG_V];
    assign c = flags[FLAG_C];

    // Select the tested relation
    always_comb begin
        unique case (cond_sel)
            4'b0001: cond_true = 1'b1;
            4'b0010: cond_true = !z;
            4'b0011: cond_true = z;
            4'b0100: cond_true = (n == v);
            4'b0101: cond_true = (n != v);
            4'b0110: cond_true = !z && (n == v);
            4'b0111: cond_true = z || (n != v);
            4'b1000: cond_true = !n;
            4'b1001: cond_true = n;
            4'b1010: cond_true = !c && !z;
            4'b1011: cond_true = c || z;
            4'b1100: cond_true = !v;
            4'b1101: cond_true = v;
            4'b1110: cond_true = !c;
            4'b1111: cond_true = c;
            default: cond_true = 1'b0;
        endcase
    end

endmodule

// File: rtl/ccb_flag_ops.sv
// Mask-driven flag set/clear unit.
// Each flag bit is handled by its own slice. It assumes mask bit i selects flag bit i.
module ccb_flag_ops #(
    parameter int FLG_W = 4
) (
    input  logic             active,
    input  logic             set_op,
    input  logic [FLG_W-1:0] mask,
    input  logic [FLG_W-1:0] flags_in,
    output logic [FLG_W-1:0] flags_out
);
    genvar i;
    generate
        for (i = 0; i < FLG_W; i++) begin : g_bit
            // Apply the set or clear to one selected flag
            always_comb begin
                if (active && mask[i]) flags_out[i] = set_op;
                else                   flags_out[i] = flags_in[i];
            end
        end
    endgenerate

endmodule

// File: rtl/ccb_target.sv
// Target address adder.
// Forms the forward/backward branch target and the backward loop target from the
// already-incremented PC. Word offsets are doubled; the result wraps at 2^W.
module ccb_target #(
    parameter int W     = 16,
    parameter int OFF_W = 8,
    parameter int CNT_W = 6
) (
    input  logic [W-1:0]     pc,
    input  logic [OFF_W-1:0] offset,
    input  logic [CNT_W-1:0] count,
    output logic [W-1:0]     br_target,
    output logic [W-1:0]     loop_target
);
    localparam int SEXT_W = W - OFF_W - 1;
    localparam int ZEXT_W = W - CNT_W - 1;

    logic [W-1:0] br_disp;
    logic [W-1:0] loop_disp;

    // Doubled, sign-extended branch displacement and doubled loop count
    assign br_disp   = {{SEXT_W{offset[OFF_W-1]}}, offset, 1'b0};
    assign loop_disp = {{ZEXT_W{1'b0}}, count, 1'b0};

    // Modular sums
    assign br_target   = pc + br_disp;
    assign loop_target = pc - loop_disp;

endmodule

// File: rtl/ccb_eval.sv
// Condition code branch evaluator (top).
// A single-cycle combinational core: it classifies the word, evaluates the branch
// condition, the loop decrement and the flag operations, and selects the next PC.
// The only state is the flag nibble register, which loads on flag operations while
// en is high. It assumes that pc_in already points past the instruction word.
module ccb_eval
    import ccb_pkg::*;
#(
    parameter int W     = 16,
    parameter int OFF_W = 8,
    parameter int CNT_W = 6,
    parameter int FLG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [W-1:0]     instr,
    input  logic [W-1:0]     pc_in,
    input  logic [FLG_W-1:0] flags_in,
    input  logic [W-1:0]     loop_reg,
    output logic             recognised,
    output logic             taken,
    output logic [W-1:0]     target_pc,
    output logic [W-1:0]     loop_dec,
    output logic [FLG_W-1:0] flags_next,
    output logic [FLG_W-1:0] flags_q
);
    localparam logic [W-1:0] EVEN_MASK = {{(W-1){1'b1}}, 1'b0};

    word_kind_t       kind;
    logic [3:0]       cond_sel;
    logic [OFF_W-1:0] offset;
    logic [CNT_W-1:0] count;
    logic [FLG_W-1:0] mask;
    logic             set_op;
    logic             cond_true;
    logic [W-1:0]     br_target;
    logic [W-1:0]     loop_target;
    logic [W-1:0]     reg_minus1;
    logic             flag_load;

    ccb_decode #(.W(W), .OFF_W(OFF_W), .CNT_W(CNT_W), .FLG_W(FLG_W)) decode_i (
        .instr    (instr),
        .kind     (kind),
        .cond_sel (cond_sel),
        .offset   (offset),
        .count    (count),
        .mask     (mask),
        .set_op   (set_op)
    );

    ccb_cond_eval #(.FLG_W(FLG_W)) cond_i (
        .cond_sel  (cond_sel),
        .flags     (flags_in),
        .cond_true (cond_true)
    );

    ccb_flag_ops #(.FLG_W(FLG_W)) flag_i (
        .active    (kind == K_FLAGOP),
        .set_op    (set_op),
        .mask      (mask),
        .flags_in  (flags_in),
        .flags_out (flags_next)
    );

    ccb_target #(.W(W), .OFF_W(OFF_W), .CNT_W(CNT_W)) target_i (
        .pc          (pc_in),
        .offset      (offset),
        .count       (count),
        .br_target   (br_target),
        .loop_target (loop_target)
    );

    assign reg_minus1 = loop_reg - 1'b1;
    assign flag_load  = en && (kind == K_FLAGOP);

    // Taken decision and next-PC selection, bit 0 always cleared
    always_comb begin
        recognised = (kind != K_NONE);
        loop_dec   = loop_reg;
        taken      = 1'b0;
        target_pc  = pc_in & EVEN_MASK;
        unique case (kind)
            K_BRANCH: begin
                taken = cond_true;
                if (cond_true) target_pc = br_target & EVEN_MASK;
            end
            K_LOOP: begin
                loop_dec = reg_minus1;
                taken    = (reg_minus1 != '0);
                if (reg_minus1 != '0) target_pc = loop_target & EVEN_MASK;
            end
            default: ;
        endcase
    end

    // Flag nibble register
    always_ff @(posedge clk) begin
        if (!rst_n)         flags_q <= '0;
        else if (flag_load) flags_q <= flags_next;
    end

    // ---------------- assertions ----------------
    p_even_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
        target_pc[0] == 1'b0);

    p_unknown_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !recognised |-> (!taken && (flags_next == flags_in) && (loop_dec == loop_reg)));

    p_flagop_no_jump_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == K_FLAGOP) |-> (!taken && recognised));

    p_loop_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == K_LOOP) |-> (taken == (loop_dec != '0)));

    p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_load |=> $stable(flags_q));

    p_flag_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flag_load |=> (flags_q == $past(flags_next)));

    p_not_taken_pc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !taken |-> (target_pc == (pc_in & EVEN_MASK)));

endmodule

// File: tb/ccb_eval_tb_top.sv
// Self-checking bench for ccb_eval: sweep of every high byte against all flag
// combinations, several offsets and PCs, then a clocked flag register sequence.
module ccb_eval_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [15:0] instr = '0;
    logic [15:0] pc_in = '0;
    logic [3:0]  flags_in = '0;
    logic [15:0] loop_reg = '0;
    logic        recognised, taken;
    logic [15:0] target_pc, loop_dec;
    logic [3:0]  flags_next, flags_q;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    ccb_eval dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .instr(instr), .pc_in(pc_in),
        .flags_in(flags_in), .loop_reg(loop_reg), .recognised(recognised),
        .taken(taken), .target_pc(target_pc), .loop_dec(loop_dec),
        .flags_next(flags_next), .flags_q(flags_q)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp, input logic [15:0] w);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s word=%h actual=%h expected=%h", req, w, act, exp);
        end
    endtask

    // Reference condition from the requirement tables (R2, R3)
    function automatic bit ref_cond(input logic [7:0] hb, input logic [3:0] f);
        bit n = f[3], z = f[2], v = f[1], c = f[0];
        case (hb)
            8'h01: return 1;
            8'h02: return !z;
            8'h03: return z;
            8'h04: return n == v;
            8'h05: return n != v;
            8'h06: return !z && n == v;
            8'h07: return z || n != v;
            8'h80: return !n;
            8'h81: return n;
            8'h82: return !c && !z;
            8'h83: return c || z;
            8'h84: return !v;
            8'h85: return v;
            8'h86: return !c;
            8'h87: return c;
            default: return 0;
        endcase
    endfunction

    task automatic sweep_one(input logic [15:0] w, input logic [15:0] pc,
                             input logic [3:0] f, input logic [15:0] lr);
        bit          e_rec, e_tk, is_br;
        logic [15:0] e_tgt, e_ld;
        logic [3:0]  e_fl;
        int          off, cnt;
        string       tag;
        @(negedge clk);
        instr = w; pc_in = pc; flags_in = f; loop_reg = lr;
        #2;
        is_br = (w[15:8] >= 8'h01 && w[15:8] <= 8'h07) || (w[15:8] >= 8'h80 && w[15:8] <= 8'h87);
        e_rec = 0; e_tk = 0; e_fl = f; e_ld = lr;
        e_tgt = pc & 16'hFFFE;
        tag = "R8";
        if (is_br) begin
            e_rec = 1;
            e_tk  = ref_cond(w[15:8], f);
            off   = (w[7:0] >= 8'd128) ? int'(w[7:0]) - 256 : int'(w[7:0]);
            if (e_tk) e_tgt = 16'(int'(pc) + 2 * off) & 16'hFFFE;
            tag = w[15] ? "R3 R1" : "R2 R1";
        end else if (w[15:9] == 7'b0111111) begin
            e_rec = 1;
            cnt   = int'(w[5:0]);
            e_ld  = 16'(int'(lr) - 1);
            e_tk  = (e_ld != 0);
            if (e_tk) e_tgt = 16'(int'(pc) - 2 * cnt) & 16'hFFFE;
            tag = "R7";
        end else if (w[15:4] == 12'h00A) begin
            e_rec = 1; e_fl = f & ~w[3:0]; tag = "R5";
        end else if (w[15:4] == 12'h00B) begin
            e_rec = 1; e_fl = f | w[3:0]; tag = "R6";
        end
        check(recognised == e_rec, {tag, " recognised"}, 32'(recognised), 32'(e_rec), w);
        check(taken == e_tk, {tag, " taken"}, 32'(taken), 32'(e_tk), w);
        check(target_pc == e_tgt, {tag, " R4 R10 target"}, 32'(target_pc), 32'(e_tgt), w);
        check(flags_next == e_fl, {tag, " flags_next"}, 32'(flags_next), 32'(e_fl), w);
        check(loop_dec == e_ld, {tag, " loop_dec"}, 32'(loop_dec), 32'(e_ld), w);
    endtask

    task automatic step_flags(input bit e, input logic [15:0] w, input logic [3:0] f,
                              input logic [3:0] exp, input string req);
        @(negedge clk);
        en = e; instr = w; flags_in = f;
        @(posedge clk);
        #1;
        check(flags_q == exp, req, 32'(flags_q), 32'(exp), w);
    endtask

    initial begin
        logic [7:0]  lows [6];
        logic [15:0] pcs  [6];
        lows = '{8'h00, 8'h7F, 8'h80, 8'hFF, 8'hA5, 8'h3B};
        pcs  = '{16'h0002, 16'hFFFE, 16'h0000, 16'h1235, 16'h8000, 16'h0100};
        repeat (3) @(posedge clk);
        #1;
        check(flags_q == 4'h0, "R9 reset", 32'(flags_q), 32'h0, 16'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check(flags_q == 4'h0, "R9 after reset", 32'(flags_q), 32'h0, 16'h0);

        // Sweep: every high byte, several low bytes and PCs, all flag values
        for (int h = 0; h < 256; h++) begin
            for (int li = 0; li < 6; li++) begin
                for (int f = 0; f < 16; f++) begin
                    logic [15:0] lr;
                    lr = (f == 0) ? 16'h0001 : (f == 1) ? 16'h0000 : 16'(f * 16'h1111);
                    sweep_one({8'(h), lows[li]}, pcs[li], 4'(f), lr);
                end
            end
        end
        // Flag set/clear words with every mask, zero mask included (R5, R6)
        for (int m = 0; m < 32; m++) begin
            sweep_one(16'h00A0 + 16'(m), 16'h0200, 4'h9, 16'h0005);
            sweep_one(16'h00A0 + 16'(m), 16'h0200, 4'h6, 16'h0005);
        end

        // Flag register load rules (R9)
        step_flags(1'b1, 16'h00BF, 4'h0, 4'hF, "R9 R6 load set-all");
        step_flags(1'b0, 16'h00A5, 4'hF, 4'hF, "R9 hold when en low");
        step_flags(1'b1, 16'h00A5, 4'hF, 4'hA, "R9 R5 load clear Z,C");
        step_flags(1'b1, 16'h1234, 4'h3, 4'hA, "R9 R8 hold on unknown word");
        step_flags(1'b1, 16'h0105, 4'h3, 4'hA, "R9 hold on branch");
        step_flags(1'b1, 16'h7E41, 4'h3, 4'hA, "R9 hold on loop");
        step_flags(1'b1, 16'h00B0, 4'h3, 4'h3, "R9 R6 zero mask loads unchanged flags");
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check(flags_q == 4'h0, "R9 reset clears", 32'(flags_q), 32'h0, 16'h0);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // Watchdog
    initial begin
        #1_900_000;
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule